// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Status Stack

This block collects six maskable interrupt sources plus a non-maskable restart request for a small signal-processing sequencer. It turns them into one request with a fixed vector address. Each maskable source can be edge-sensitive or level-sensitive:

- An edge-sensitive source sets a pending latch on a rising edge.
- A level-sensitive source is used directly from its input.

A programmable enable mask filters the pending requests. The lowest-numbered enabled request wins, and its vector is presented on `int_vec`.

When the sequencer acknowledges a maskable interrupt, the controller pushes three words onto an internal stack: the arithmetic status, the mode status and the current enable mask. It then narrows the mask so that only higher-priority sources can nest. A return strobe pops the stack and hands the saved words back. A write-only force/clear port lets software set or drop pending latches. Sticky flags record a push into a full stack and a pop from an empty one.

Top module: `vic_stack`

## Requirements
- R1: After reset the enable mask is 0, the stack depth is 0, both sticky flags are 0, `astat_out`, `mstat_out` and `rti_done` are 0, and `int_req` is 0 while `boot_req` is low.
- R2: `boot_req` high gives `int_req`=1 and `int_vec`=0x0000 regardless of the mask. Otherwise, maskable source k (bit k of `irq_in`) maps to vector 4*(k+1):
  - bit 0 (external request) maps to 0x0004;
  - bits 1 and 2 (port-0 transmit and receive) map to 0x0008 and 0x000C;
  - bits 3 and 4 (port-1 transmit and receive) map to 0x0010 and 0x0014;
  - bit 5 (timer) maps to 0x0018.
- R3: Mask bit k = 1 enables source k. Among enabled active sources, the lowest bit index is selected.
- R4: With `level_sel[k]`=0, a rising edge on `irq_in[k]` sets a pending latch seen one clock later. The latch stays set after the input falls, until source k is acknowledged or cleared.
- R5: With `level_sel[k]`=1, source k is active exactly while `irq_in[k]` is high, with no clock delay and no latching.
- R6: A write (`fc_we`=1) with `fc_force[k]`=1 sets the latch of source k, and `fc_clear[k]`=1 drops it. Both take effect at the next clock. A clear wins over a force or a rising edge on the same bit in the same cycle.
- R7: Force and clear have no effect on sources with `level_sel[k]`=1.
- R8: `int_ack` while `int_req`=1 and `boot_req`=0 does the following when the stack holds fewer than 7 entries:
  - pushes {`astat_in`, `mstat_in`, mask};
  - increments the depth;
  - clears the latch of the selected source k;
  - replaces the mask with mask AND (2^k - 1).
  `int_ack` is ignored while `int_req`=0.
- R9: `rti` with a non-empty stack pops the newest entry at the next clock. It drives the saved words on `astat_out`/`mstat_out`, restores the mask, decrements the depth and pulses `rti_done` for one cycle. Entries come back last-in, first-out.
- R10: An acknowledge at depth 7 discards the push and sets the sticky `stk_ovf`. Depth and mask are unchanged, and the selected latch is still cleared.
- R11: `rti` at depth 0 sets the sticky `stk_udf`. It leaves `astat_out`, `mstat_out`, the mask and the depth unchanged, and gives no `rti_done`.
- R12: Acknowledging while `boot_req`=1 empties the stack and sets the mask to 0, without a push.
- R13: When `int_ack` (with a request) and `rti` arrive in the same cycle, only the acknowledge is performed.
- R14: `mask_we` loads `mask_wdata` into the mask at the next clock, unless an acknowledge (with a request) or an `rti` falls in the same cycle, in which case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIRQ | Maskable source inputs, bit 0 highest priority |
| level_sel | input | NIRQ | 1 = source is level-sensitive |
| boot_req | input | 1 | Non-maskable restart request (vector 0) |
| fc_we | input | 1 | Force/clear write strobe |
| fc_force | input | NIRQ | Force bits |
| fc_clear | input | NIRQ | Clear bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NIRQ | New mask value |
| astat_in | input | SW | Arithmetic status word to save |
| mstat_in | input | SW | Mode status word to save |
| int_ack | input | 1 | Sequencer takes the presented interrupt |
| rti | input | 1 | Return-from-interrupt strobe |
| int_req | output | 1 | An interrupt is presented |
| int_vec | output | VW | Vector address of the presented interrupt |
| mask_out | output | NIRQ | Current enable mask |
| astat_out | output | SW | Restored arithmetic status |
| mstat_out | output | SW | Restored mode status |
| rti_done | output | 1 | One-cycle pulse after a successful pop |
| stk_depth | output | DW | Number of stacked entries |
| stk_ovf | output | 1 | Sticky push-into-full flag |
| stk_udf | output | 1 | Sticky pop-from-empty flag |

## Verification
Three pairs of operations can fall in the same cycle, and each is provoked on purpose:

- a clear and a force on one latch bit, and separately a clear and a fresh rising edge on one latch bit;
- an acknowledge and a return strobe;
- an acknowledge and a mask write.

For each pair the bench drives both inputs for a single clock and then judges the outcome at the ports. A contested latch must leave `int_req` low. The acknowledge must win, which the bench sees as a depth that rose by one with no `rti_done`, and as a mask equal to the narrowed entry mask rather than the written value.

// File: rtl/vic_stack.sv
module vic_stack #(
  parameter int NIRQ  = 6,
  parameter int SW    = 16,
  parameter int DEPTH = 7,
  parameter int VW    = 14,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(NIRQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] level_sel,
  input  logic            boot_req,
  input  logic            fc_we,
  input  logic [NIRQ-1:0] fc_force,
  input  logic [NIRQ-1:0] fc_clear,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_wdata,
  input  logic [SW-1:0]   astat_in,
  input  logic [SW-1:0]   mstat_in,
  input  logic            int_ack,
  input  logic            rti,
  output logic            int_req,
  output logic [VW-1:0]   int_vec,
  output logic [NIRQ-1:0] mask_out,
  output logic [SW-1:0]   astat_out,
  output logic [SW-1:0]   mstat_out,
  output logic            rti_done,
  output logic [DW-1:0]   stk_depth,
  output logic            stk_ovf,
  output logic            stk_udf
);

  logic [NIRQ-1:0] pend, irq_d, mask_q, eff, act, fc_f, fc_c, take_bit;
  logic [SW-1:0]   st_a [DEPTH];
  logic [SW-1:0]   st_m [DEPTH];
  logic [NIRQ-1:0] st_k [DEPTH];
  logic [DW-1:0]   depth, top;
  logic [IW-1:0]   sel;
  logic            any, take, take_boot, take_irq, full, push_ok, pop, pop_ok;

  assign eff = (level_sel & irq_in) | (~level_sel & pend);
  assign act = eff & mask_q;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = NIRQ - 1; k >= 0; k--)
      if (act[k]) begin
        any = 1'b1;
        sel = IW'(k);
      end
  end

  assign int_req   = boot_req | any;
  assign int_vec   = boot_req ? '0 : (VW'(sel) + VW'(1)) << 2;

  assign take      = int_ack & int_req;
  assign take_boot = take & boot_req;
  assign take_irq  = take & ~boot_req;
  assign full      = (depth == DW'(DEPTH));
  assign push_ok   = take_irq & ~full;
  assign pop       = rti & ~take;
  assign pop_ok    = pop & (depth != '0);
  assign top       = depth - DW'(1);
  assign take_bit  = take_irq ? (NIRQ'(1) << sel) : '0;

  assign fc_f = fc_we ? (fc_force & ~level_sel) : '0;
  assign fc_c = fc_we ? (fc_clear & ~level_sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_d <= '0;
      pend  <= '0;
    end else begin
      irq_d <= irq_in;
      pend  <= (pend | (irq_in & ~irq_d) | fc_f) & ~fc_c & ~take_bit & ~level_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      depth     <= '0;
      astat_out <= '0;
      mstat_out <= '0;
      rti_done  <= 1'b0;
      stk_ovf   <= 1'b0;
      stk_udf   <= 1'b0;
    end else begin
      rti_done <= pop_ok;
      if (take_irq && full) stk_ovf <= 1'b1;
      if (pop && depth == '0) stk_udf <= 1'b1;
      if (take_boot) begin
        depth  <= '0;
        mask_q <= '0;
      end else if (push_ok) begin
        depth  <= depth + DW'(1);
        mask_q <= mask_q & ((NIRQ'(1) << sel) - NIRQ'(1));
      end else if (pop_ok) begin
        depth     <= top;
        mask_q    <= st_k[top];
        astat_out <= st_a[top];
        mstat_out <= st_m[top];
      end else if (mask_we && !take && !rti) begin
        mask_q <= mask_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      st_a[depth] <= astat_in;
      st_m[depth] <= mstat_in;
      st_k[depth] <= mask_q;
    end
  end

  assign mask_out  = mask_q;
  assign stk_depth = depth;

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= DW'(DEPTH)); // R10
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && int_req && !boot_req && stk_depth < DW'(DEPTH) |=> stk_depth == $past(stk_depth) + DW'(1)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && int_req && !boot_req && stk_depth == DW'(DEPTH) |=> stk_ovf && $stable(stk_depth) && $stable(mask_out)); // R10
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rti && !(int_ack && int_req) && stk_depth == '0 |=> stk_udf && $stable(astat_out) && $stable(mstat_out) && !rti_done); // R11
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rti && !(int_ack && int_req) && stk_depth != '0 |=> rti_done && stk_depth == $past(stk_depth) - DW'(1)); // R9
  AST_ACK_BEATS_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    rti && int_ack && int_req |=> !rti_done); // R13
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf || stk_udf |=> $countones({stk_ovf, stk_udf}) >= $past($countones({stk_ovf, stk_udf}))); // R10
  AST_BOOT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req |-> int_req && int_vec == '0); // R2

endmodule

// File: tb/test_vic_stack.sv
module test_vic_stack;
  localparam int NIRQ = 6, SW = 16, DEPTH = 7, VW = 14, DW = 3;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [NIRQ-1:0] irq_in = '0, level_sel = '0, fc_force = '0, fc_clear = '0, mask_wdata = '0;
  logic            boot_req = 1'b0, fc_we = 1'b0, mask_we = 1'b0, int_ack = 1'b0, rti = 1'b0;
  logic [SW-1:0]   astat_in = '0, mstat_in = '0;
  logic            int_req, rti_done, stk_ovf, stk_udf;
  logic [VW-1:0]   int_vec;
  logic [NIRQ-1:0] mask_out;
  logic [SW-1:0]   astat_out, mstat_out;
  logic [DW-1:0]   stk_depth;

  int total = 0, bad = 0;

  vic_stack #(.NIRQ(NIRQ), .SW(SW), .DEPTH(DEPTH), .VW(VW)) i_vic_stack (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel), .boot_req(boot_req),
    .fc_we(fc_we), .fc_force(fc_force), .fc_clear(fc_clear), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .astat_in(astat_in), .mstat_in(mstat_in), .int_ack(int_ack),
    .rti(rti), .int_req(int_req), .int_vec(int_vec), .mask_out(mask_out),
    .astat_out(astat_out), .mstat_out(mstat_out), .rti_done(rti_done),
    .stk_depth(stk_depth), .stk_ovf(stk_ovf), .stk_udf(stk_udf));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mask(input logic [NIRQ-1:0] m);
    mask_we = 1'b1; mask_wdata = m; tick(); mask_we = 1'b0;
  endtask

  task automatic force_bits(input logic [NIRQ-1:0] f, input logic [NIRQ-1:0] c);
    fc_we = 1'b1; fc_force = f; fc_clear = c; tick(); fc_we = 1'b0; fc_force = '0; fc_clear = '0;
  endtask

  task automatic ack();
    int_ack = 1'b1; tick(); int_ack = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 int_req", int_req, 0);
    chk("R1 depth", stk_depth, 0);
    chk("R1 flags", {stk_ovf, stk_udf}, 0);
    chk("R1 mask", mask_out, 0);
    chk("R1 status", {astat_out, mstat_out, rti_done}, 0);
  endtask

  task automatic t_vectors();
    set_mask('1);
    level_sel = '1;
    for (int k = 0; k < NIRQ; k++) begin
      irq_in = NIRQ'(1) << k; #1;
      chk("R2 vector", int_vec, 4 * (k + 1));
      chk("R5 level direct", int_req, 1);
    end
    boot_req = 1'b1; #1;
    chk("R2 boot vector", int_vec, 0);
    boot_req = 1'b0; irq_in = '0; #1;
    chk("R5 level drop", int_req, 0);
  endtask

  task automatic t_priority();
    irq_in = 6'b101100; #1;
    chk("R3 lowest index", int_vec, 14'h00C);
    set_mask(6'b111011); #1;
    chk("R3 masked skip", int_vec, 14'h010);
    set_mask(6'b000011); #1;
    chk("R3 all masked", int_req, 0);
    irq_in = '0; level_sel = '0; set_mask('1);
  endtask

  task automatic t_edge();
    irq_in[3] = 1'b1; #1;
    chk("R4 no same-cycle", int_req, 0);
    tick();
    chk("R4 latched", int_vec, 14'h010);
    irq_in[3] = 1'b0; tick();
    chk("R4 held", int_req, 1);
    astat_in = 16'hA0A0; mstat_in = 16'h0B0B;
    ack();
    chk("R8 latch cleared", int_req, 0);
    chk("R8 depth", stk_depth, 1);
    chk("R8 entry mask", mask_out, 6'b000111);
    ret();
    chk("R9 restore mask", mask_out, 6'b111111);
    chk("R9 astat", astat_out, 16'hA0A0);
  endtask

  task automatic t_level();
    level_sel[4] = 1'b1;
    irq_in[4] = 1'b1; tick();
    irq_in[4] = 1'b0; #1;
    chk("R5 not latched", int_req, 0);
    tick();
    chk("R5 still clear", int_req, 0);
    level_sel[4] = 1'b0;
  endtask

  task automatic t_force_clear();
    force_bits(6'b100000, '0);
    chk("R6 force", int_vec, 14'h018);
    force_bits('0, 6'b100000);
    chk("R6 clear", int_req, 0);
    force_bits(6'b100000, 6'b100000);
    chk("R6 clear beats force", int_req, 0);
    irq_in[1] = 1'b1;
    force_bits('0, 6'b000010);
    chk("R6 clear beats edge", int_req, 0);
    irq_in[1] = 1'b0; tick();
  endtask

  task automatic t_level_exempt();
    level_sel[2] = 1'b1;
    force_bits(6'b000100, '0);
    chk("R7 force ignored", int_req, 0);
    irq_in[2] = 1'b1;
    force_bits('0, 6'b000100);
    chk("R7 clear ignored", int_vec, 14'h00C);
    irq_in[2] = 1'b0; level_sel[2] = 1'b0; tick();
  endtask

  task automatic t_nest();
    astat_in = 16'h1111; mstat_in = 16'h2222;
    force_bits(6'b100000, '0);
    ack();
    chk("R8 first mask", mask_out, 6'b011111);
    astat_in = 16'h3333; mstat_in = 16'h4444;
    force_bits(6'b000010, '0);
    chk("R8 nest vector", int_vec, 14'h008);
    ack();
    chk("R8 depth two", stk_depth, 2);
    chk("R8 narrow mask", mask_out, 6'b000001);
    int_ack = 1'b1; force_bits(6'b001000, '0); int_ack = 1'b0;
    chk("R8 masked during service", int_req, 0);
    chk("R8 ack without request", stk_depth, 2);
    ret();
    chk("R9 pulse", rti_done, 1);
    chk("R9 LIFO status", {astat_out, mstat_out}, 32'h33334444);
    chk("R9 mask back", mask_out, 6'b011111);
    #1 chk("R9 pending now visible", int_vec, 14'h010);
    tick();
    chk("R9 pulse one cycle", rti_done, 0);
    force_bits('0, 6'b001000);
    ret();
    chk("R9 second pop", {astat_out, mstat_out}, 32'h11112222);
    chk("R9 empty", stk_depth, 0);
    chk("R9 full mask", mask_out, 6'b111111);
  endtask

  task automatic t_overflow();
    astat_in = 16'h1234; mstat_in = 16'h5678;
    for (int n = 0; n < DEPTH; n++) begin
      set_mask('1);
      force_bits(6'b000001, '0);
      ack();
    end
    chk("R10 full depth", stk_depth, 7);
    chk("R10 no flag yet", stk_ovf, 0);
    set_mask('1);
    force_bits(6'b000001, '0);
    ack();
    chk("R10 overflow flag", stk_ovf, 1);
    chk("R10 depth kept", stk_depth, 7);
    chk("R10 mask kept", mask_out, 6'b111111);
    chk("R10 latch cleared", int_req, 0);
    for (int n = 0; n < DEPTH; n++) ret();
    chk("R10 sticky", stk_ovf, 1);
    chk("R9 drained", stk_depth, 0);
    ret();
    chk("R11 underflow", stk_udf, 1);
    chk("R11 status kept", {astat_out, mstat_out}, 32'h12345678);
    chk("R11 mask kept", mask_out, 6'b111111);
    chk("R11 no pulse", rti_done, 0);
    chk("R11 depth kept", stk_depth, 0);
  endtask

  task automatic t_ack_rti();
    force_bits(6'b001000, '0);
    ack();
    force_bits(6'b000010, '0);
    int_ack = 1'b1; rti = 1'b1; tick(); int_ack = 1'b0; rti = 1'b0;
    chk("R13 ack wins depth", stk_depth, 2);
    chk("R13 no pop", rti_done, 0);
    chk("R13 mask", mask_out, 6'b000001);
    ret(); ret();
    chk("R13 unwound", stk_depth, 0);
  endtask

  task automatic t_mask_write();
    force_bits(6'b000001, '0);
    int_ack = 1'b1; mask_we = 1'b1; mask_wdata = 6'b101010; tick();
    int_ack = 1'b0; mask_we = 1'b0;
    chk("R14 write dropped on ack", mask_out, 6'b000000);
    rti = 1'b1; mask_we = 1'b1; tick(); rti = 1'b0; mask_we = 1'b0;
    chk("R14 write dropped on rti", mask_out, 6'b111111);
    set_mask(6'b010101);
    chk("R14 write", mask_out, 6'b010101);
    set_mask('1);
  endtask

  task automatic t_boot();
    force_bits(6'b010000, '0);
    ack();
    set_mask('0);
    boot_req = 1'b1; #1;
    chk("R12 boot presented", {int_req, int_vec}, {1'b1, 14'h000});
    ack();
    boot_req = 1'b0; #1;
    chk("R12 stack emptied", stk_depth, 0);
    chk("R12 mask zero", mask_out, 0);
    chk("R12 no request", int_req, 0);
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    t_reset();
    t_vectors();
    t_priority();
    t_edge();
    t_level();
    t_force_clear();
    t_level_exempt();
    t_nest();
    t_overflow();
    t_ack_rti();
    t_mask_write();
    t_boot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule